// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

This block is a 32-bit up-counter driven through a 32-bit prescaler. The prescaler is fed either by every system clock cycle or by rising edges of a synchronized external event input, and the counter advances each time the prescaler wraps. Four compare channels watch the count. Each one can raise a sticky interrupt flag, zero the count, halt counting, and drive its own output pin. Four capture inputs each record the count on a chosen edge.

Software reaches the block through a word-addressed register port. A write is a single-cycle strobe. A read is combinational from the address. A compare channel acts in the cycle where the count sits at the compare value and the prescaler wraps. This means a channel that resets on match produces a count that runs from zero through the compare value inclusive.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads zero, the count is zero, `matchOut` is all zero and `irq` is low.
- R2: While enabled in clock mode with prescale limit P, the prescaler counts 0..P and the count rises by one on each prescaler wrap, which is once every P+1 cycles.
- R3: With the enable bit (control bit 0) clear, the count and the prescaler hold their values.
- R4: While the hold bit (control bit 1) is set, the count and the prescaler are forced to zero.
- R5: With event mode (control bit 2) set, the prescaler advances only on rising edges of `evIn`. `evIn` passes through two synchronizing flops first. Each high and low phase must last at least one clock.
- R6: A compare hit on channel i occurs when the prescaler wraps while the count equals that channel's compare value. If the channel's interrupt bit (action bit 3i) is set, the hit sets status bit i.
- R7: On a hit with the channel's reset bit (action bit 3i+1) set, the count and the prescaler become zero, so the count never exceeds the compare value.
- R8: On a hit with the channel's stop bit (action bit 3i+2) set, the count stays at the compare value and the enable bit is cleared. The stop takes precedence over a control write in the same cycle.
- R9: On a hit, output i follows its 2-bit code at bits 2i+1:2i of the output-action register: 0 keeps the pin, 1 drives it low, 2 drives it high, 3 inverts it.
- R10: Capture input i is synchronized by two flops. Its capture register loads the count on a rising edge if config bit 3i is set, and on a falling edge if bit 3i+1 is set. If bit 3i+2 is also set, the capture sets status bit 4+i.
- R11: The status register holds compare flags in bits 3:0 and capture flags in bits 7:4. The flags are sticky. Writing 1 to a bit clears it, but a new event in the same cycle wins. `irq` is high whenever any status bit is set.
- R12: The register map is as follows: 0 control, 1 prescale limit, 2 count, 3 prescaler, 4 status, 5 compare actions, 6 output actions, 7 capture config, 8..11 compare values, 12..15 capture values. Writes to 2, 3 and 12..15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| evIn | input | 1 | External event input (asynchronous) |
| capIn | input | 4 | Capture inputs (asynchronous) |
| matchOut | output | 4 | Compare-channel output pins |
| irq | output | 1 | OR of all status flags |

## Verification
The hardest state to reach is a compare hit that coincides with another event in the same cycle. Examples are a stop hit landing together with an output action on other channels, or a capture edge arriving a fixed distance after another. The stimulus handles this by stopping the counter with prescale limit zero, so the count is a cycle counter. Compare values on several channels are set equal so that their hits share one cycle. Capture pulses are of known width, so the two captured counts must differ by exactly that width. A behavioural model in the bench runs alongside and compares the read data, pins and `irq` on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic tick;    // prescaler may advance this cycle
    logic wrap;    // prescaler at or past its limit on a tick
    logic clear;   // zero count and prescaler
    logic freeze;  // hold count on this wrap
  } cnt_strobe_t;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'd0,
    OUT_LOW    = 2'd1,
    OUT_HIGH   = 2'd2,
    OUT_TOGGLE = 2'd3
  } out_act_e;

  localparam logic [3:0] ADDR_CTRL   = 4'd0;
  localparam logic [3:0] ADDR_PSLIM  = 4'd1;
  localparam logic [3:0] ADDR_COUNT  = 4'd2;
  localparam logic [3:0] ADDR_PSCNT  = 4'd3;
  localparam logic [3:0] ADDR_STATUS = 4'd4;
  localparam logic [3:0] ADDR_MACT   = 4'd5;
  localparam logic [3:0] ADDR_OACT   = 4'd6;
  localparam logic [3:0] ADDR_CCFG   = 4'd7;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage1Q, stage2Q, prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Q <= '0;
      stage2Q <= '0;
      prevQ   <= '0;
    end else begin
      stage1Q <= din;
      stage2Q <= stage1Q;
      prevQ   <= stage2Q;
    end
  end

  assign level = stage2Q;
  assign prev  = prevQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] psCount
);
  logic [CNT_W-1:0] countQ, psQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      psQ    <= '0;
    end else if (strobe.clear) begin
      countQ <= '0;
      psQ    <= '0;
    end else if (strobe.tick) begin
      if (strobe.wrap) begin
        psQ <= '0;
        if (!strobe.freeze) countQ <= countQ + 1'b1;
      end else begin
        psQ <= psQ + 1'b1;
      end
    end
  end

  assign count   = countQ;
  assign psCount = psQ;

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.clear) |=> ($stable(countQ) && $stable(psQ)));

  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (countQ == '0 && psQ == '0));

  a_r2_ps_steps: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.wrap && !strobe.clear)
      |=> (psQ == $past(psQ) + 1'b1 && $stable(countQ)));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NCH   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [3:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             evIn,
  input  logic [NCH-1:0]   capIn,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] psCount,
  output cnt_strobe_t      strobe,
  output logic [NCH-1:0]   matchOut,
  output logic             irq
);
  localparam int ST_W  = 2 * NCH;
  localparam int ACT_W = 3 * NCH;
  localparam int OA_W  = 2 * NCH;
  localparam int SYN_W = NCH + 1;

  logic [2:0]       ctrlQ;
  logic [CNT_W-1:0] psLimQ;
  logic [ST_W-1:0]  statusQ;
  logic [ACT_W-1:0] mActQ, cCfgQ;
  logic [OA_W-1:0]  oActQ;
  logic [CNT_W-1:0] mValQ [NCH];
  logic [CNT_W-1:0] capQ  [NCH];
  logic [NCH-1:0]   outQ, outNext;

  logic [SYN_W-1:0] synLevel, synPrev, rise, fall;
  logic [NCH-1:0]   hit, irqEn, rstEn, stopEn, capEv, capIrq;
  logic [ST_W-1:0]  setMask, clrMask;
  logic             tick, wrapNow, rstHit, stopHit;

  tmr_sync_edge #(.W(SYN_W)) uSync (
    .clk   (clk),
    .rstN  (rstN),
    .din   ({evIn, capIn}),
    .level (synLevel),
    .prev  (synPrev)
  );

  assign rise = synLevel & ~synPrev;
  assign fall = ~synLevel & synPrev;

  assign tick    = ctrlQ[0] & ~ctrlQ[1] & (ctrlQ[2] ? rise[NCH] : 1'b1);
  assign wrapNow = tick && (psCount >= psLimQ);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign irqEn[i]  = mActQ[3*i];
    assign rstEn[i]  = mActQ[3*i+1];
    assign stopEn[i] = mActQ[3*i+2];
    assign capIrq[i] = cCfgQ[3*i+2];
    assign hit[i]    = wrapNow && (count == mValQ[i]);
    assign capEv[i]  = (rise[i] & cCfgQ[3*i]) | (fall[i] & cCfgQ[3*i+1]);

    always_comb begin
      outNext[i] = outQ[i];
      if (hit[i]) begin
        case (out_act_e'(oActQ[2*i +: 2]))
          OUT_LOW:    outNext[i] = 1'b0;
          OUT_HIGH:   outNext[i] = 1'b1;
          OUT_TOGGLE: outNext[i] = ~outQ[i];
          default:    outNext[i] = outQ[i];
        endcase
      end
    end

    a_r9_drive_low: assert property (@(posedge clk) disable iff (!rstN)
      (hit[i] && oActQ[2*i +: 2] == 2'd1) |=> !matchOut[i]);

    a_r10_capture_count: assert property (@(posedge clk) disable iff (!rstN)
      capEv[i] |=> (capQ[i] == $past(count)));
  end

  assign rstHit  = |(hit & rstEn);
  assign stopHit = |(hit & stopEn);
  assign setMask = {capEv & capIrq, hit & irqEn};
  assign clrMask = (wrEn && addr == ADDR_STATUS) ? wrData[ST_W-1:0] : '0;

  always_comb begin
    strobe.tick   = tick;
    strobe.wrap   = wrapNow;
    strobe.clear  = ctrlQ[1] | rstHit;
    strobe.freeze = stopHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      psLimQ  <= '0;
      statusQ <= '0;
      mActQ   <= '0;
      cCfgQ   <= '0;
      oActQ   <= '0;
      outQ    <= '0;
      for (int i = 0; i < NCH; i++) begin
        mValQ[i] <= '0;
        capQ[i]  <= '0;
      end
    end else begin
      if (wrEn) begin
        case (addr)
          ADDR_CTRL:  ctrlQ  <= wrData[2:0];
          ADDR_PSLIM: psLimQ <= wrData;
          ADDR_MACT:  mActQ  <= wrData[ACT_W-1:0];
          ADDR_OACT:  oActQ  <= wrData[OA_W-1:0];
          ADDR_CCFG:  cCfgQ  <= wrData[ACT_W-1:0];
          default: begin
            if (addr[3:2] == 2'b10 && int'(addr[1:0]) < NCH)
              mValQ[addr[1:0]] <= wrData;
          end
        endcase
      end
      if (stopHit) ctrlQ[0] <= 1'b0;
      statusQ <= (statusQ & ~clrMask) | setMask;
      outQ    <= outNext;
      for (int i = 0; i < NCH; i++) begin
        if (capEv[i]) capQ[i] <= count;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL:   rdData[2:0]       = ctrlQ;
      ADDR_PSLIM:  rdData            = psLimQ;
      ADDR_COUNT:  rdData            = count;
      ADDR_PSCNT:  rdData            = psCount;
      ADDR_STATUS: rdData[ST_W-1:0]  = statusQ;
      ADDR_MACT:   rdData[ACT_W-1:0] = mActQ;
      ADDR_OACT:   rdData[OA_W-1:0]  = oActQ;
      ADDR_CCFG:   rdData[ACT_W-1:0] = cCfgQ;
      default: begin
        if (addr[3] && int'(addr[1:0]) < NCH)
          rdData = addr[2] ? capQ[addr[1:0]] : mValQ[addr[1:0]];
      end
    endcase
  end

  assign matchOut = outQ;
  assign irq      = |statusQ;

  a_r8_stop_disables: assert property (@(posedge clk) disable iff (!rstN)
    stopHit |=> !ctrlQ[0]);

  a_r7_reset_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    rstHit |=> (count == '0));

  a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_STATUS) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  a_r6_hit_flags: assert property (@(posedge clk) disable iff (!rstN)
    (|(hit & irqEn)) |=> irq);
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NCH   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [3:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             evIn,
  input  logic [NCH-1:0]   capIn,
  output logic [NCH-1:0]   matchOut,
  output logic             irq
);
  cnt_strobe_t      strobe;
  logic [CNT_W-1:0] count, psCount;

  tmr_ctrl #(.CNT_W(CNT_W), .NCH(NCH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .evIn     (evIn),
    .capIn    (capIn),
    .count    (count),
    .psCount  (psCount),
    .strobe   (strobe),
    .matchOut (matchOut),
    .irq      (irq)
  );

  tmr_datapath #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .count   (count),
    .psCount (psCount)
  );
endmodule

// File: tb/tb_tmr_match_capture.sv
`timescale 1ns/1ps
module tb_tmr_match_capture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'd2;
  logic [31:0] wrData = '0;
  logic        evIn = 1'b0;
  logic [3:0]  capIn = '0;
  logic [31:0] rdData;
  logic [3:0]  matchOut;
  logic        irq;

  always #2.5 clk = ~clk;

  tmr_match_capture dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evIn(evIn), .capIn(capIn), .matchOut(matchOut), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // behavioural reference state
  logic [2:0]  mCtrl = '0;
  logic [31:0] mPsLim = '0, mCount = '0, mPs = '0;
  logic [7:0]  mStatus = '0, mOA = '0, mSet, mClr;
  logic [11:0] mAct = '0, mCfg = '0;
  logic [31:0] mVal [4] = '{default: '0};
  logic [31:0] mCap [4] = '{default: '0};
  logic [3:0]  mOut = '0, mOutN;
  logic [4:0]  mS1 = '0, mS2 = '0, mPv = '0, mRise, mFall;
  logic        mTick, mWrap, mRst, mStop;

  function automatic logic [31:0] mRead(input logic [3:0] a);
    case (a)
      4'd0: return {29'd0, mCtrl};
      4'd1: return mPsLim;
      4'd2: return mCount;
      4'd3: return mPs;
      4'd4: return {24'd0, mStatus};
      4'd5: return {20'd0, mAct};
      4'd6: return {24'd0, mOA};
      4'd7: return {20'd0, mCfg};
      default: return a[2] ? mCap[a[1:0]] : mVal[a[1:0]];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mPsLim = '0; mCount = '0; mPs = '0; mStatus = '0;
      mOA = '0; mAct = '0; mCfg = '0; mOut = '0;
      mS1 = '0; mS2 = '0; mPv = '0;
      for (int i = 0; i < 4; i++) begin mVal[i] = '0; mCap[i] = '0; end
    end else begin
      mRise = mS2 & ~mPv;
      mFall = ~mS2 & mPv;
      mTick = mCtrl[0] && !mCtrl[1] && (mCtrl[2] ? mRise[4] : 1'b1);
      mWrap = mTick && (mPs >= mPsLim);
      mSet = '0; mClr = '0; mRst = 1'b0; mStop = 1'b0; mOutN = mOut;
      for (int i = 0; i < 4; i++) begin
        if (mWrap && mCount == mVal[i]) begin
          if (mAct[3*i])   mSet[i] = 1'b1;
          if (mAct[3*i+1]) mRst = 1'b1;
          if (mAct[3*i+2]) mStop = 1'b1;
          case (mOA[2*i +: 2])
            2'd1: mOutN[i] = 1'b0;
            2'd2: mOutN[i] = 1'b1;
            2'd3: mOutN[i] = ~mOut[i];
            default: ;
          endcase
        end
        if ((mRise[i] && mCfg[3*i]) || (mFall[i] && mCfg[3*i+1])) begin
          mCap[i] = mCount;
          if (mCfg[3*i+2]) mSet[4+i] = 1'b1;
        end
      end
      mOut = mOutN;
      if (mCtrl[1] || mRst) begin
        mCount = '0; mPs = '0;
      end else if (mTick) begin
        if (mWrap) begin
          mPs = '0;
          if (!mStop) mCount = mCount + 1;
        end else mPs = mPs + 1;
      end
      if (wrEn) begin
        case (addr)
          4'd0: mCtrl = wrData[2:0];
          4'd1: mPsLim = wrData;
          4'd4: mClr = wrData[7:0];
          4'd5: mAct = wrData[11:0];
          4'd6: mOA = wrData[7:0];
          4'd7: mCfg = wrData[11:0];
          4'd8, 4'd9, 4'd10, 4'd11: mVal[addr[1:0]] = wrData;
          default: ;
        endcase
      end
      if (mStop) mCtrl[0] = 1'b0;
      mStatus = (mStatus & ~mClr) | mSet;
      mPv = mS2; mS2 = mS1; mS1 = {evIn, capIn};
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // lock-step comparison on every falling edge
  always @(negedge clk) begin
    check({tag, " rdData"}, rdData, mRead(addr));
    check({tag, " matchOut"}, {28'd0, matchOut}, {28'd0, mOut});
    check({tag, " irq"}, {31'd0, irq}, {31'd0, |mStatus});
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0; addr = 4'd2;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    addr = a; #1;
    v = rdData;
  endtask

  logic [31:0] v0, v1;
  int maxSeen;

  initial begin
    idle(3); #1 rstN = 1'b1;
    tag = "R1";
    rd(4'd0, v0); check("R1 ctrl", v0, 0);
    rd(4'd2, v0); check("R1 count", v0, 0);
    rd(4'd4, v0); check("R1 status", v0, 0);
    check("R1 pins", {28'd0, matchOut}, 0);
    check("R1 irq", {31'd0, irq}, 0);

    tag = "R12";
    wr(4'd1, 32'd2); rd(4'd1, v0); check("R12 prescale readback", v0, 2);
    wr(4'd8, 32'd5); rd(4'd8, v0); check("R12 compare readback", v0, 5);
    wr(4'd12, 32'd77); rd(4'd12, v0); check("R12 capture write ignored", v0, 0);
    wr(4'd2, 32'd9); rd(4'd2, v0); check("R12 count write ignored", v0, 0);

    tag = "R2";
    wr(4'd0, 32'd1); idle(2);
    rd(4'd2, v0); idle(8); rd(4'd2, v1);
    check("R2 three steps in nine cycles", v1 - v0, 3);
    rd(4'd3, v0); check("R2 prescaler within limit", {31'd0, v0 <= 2}, 1);

    tag = "R3";
    wr(4'd0, 32'd0);
    rd(4'd2, v0); idle(5); rd(4'd2, v1); check("R3 count holds", v1, v0);

    tag = "R4";
    wr(4'd0, 32'd3); idle(3);
    rd(4'd2, v0); check("R4 count zero", v0, 0);
    rd(4'd3, v0); check("R4 prescaler zero", v0, 0);

    tag = "R7";
    wr(4'd5, 32'h3);          // ch0: interrupt + reset
    wr(4'd6, 32'h3);          // ch0: toggle
    wr(4'd0, 32'd1);
    maxSeen = 0;
    addr = 4'd2;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); #1;
      if (int'(rdData) > maxSeen) maxSeen = int'(rdData);
    end
    check("R7 count capped at compare value", maxSeen, 5);
    rd(4'd4, v0); check("R6 compare flag set", v0 & 32'h1, 1);

    tag = "R11";
    wr(4'd0, 32'd0);
    wr(4'd4, 32'hFF);
    rd(4'd4, v0); check("R11 flags cleared", v0, 0);
    check("R11 irq low", {31'd0, irq}, 0);

    tag = "R8";
    wr(4'd0, 32'd2);
    wr(4'd1, 32'd0);
    wr(4'd5, 32'h020);        // ch1 stop
    wr(4'd9, 32'd3);
    wr(4'd10, 32'd3);
    wr(4'd6, 32'h27);         // ch0 toggle, ch1 low, ch2 high
    wr(4'd0, 32'd1);
    idle(20);
    rd(4'd2, v0); check("R8 count held at compare value", v0, 3);
    rd(4'd0, v0); check("R8 enable cleared", v0 & 32'h1, 0);
    check("R9 high action", {31'd0, matchOut[2]}, 1);
    check("R9 low action", {31'd0, matchOut[1]}, 0);

    tag = "R5";
    wr(4'd0, 32'd2);
    wr(4'd5, 32'd0);
    wr(4'd0, 32'd5);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1 evIn = 1'b1; idle(1); #1;
      idle(1); #1 evIn = 1'b0; idle(2);
    end
    idle(4);
    rd(4'd2, v0); check("R5 five events counted", v0, 5);

    tag = "R10";
    wr(4'd0, 32'd2);
    wr(4'd4, 32'hFF);
    wr(4'd7, 32'h540);        // ch2 rising + flag, ch3 falling
    wr(4'd0, 32'd1);
    idle(3);
    @(negedge clk); #1 capIn = 4'b1100;
    idle(4); #1 capIn = 4'b0000;
    idle(5);
    rd(4'd14, v0); rd(4'd15, v1);
    check("R10 edge spacing", v1 - v0, 4);
    check("R10 rising capture nonzero", {31'd0, v0 != 0}, 1);
    rd(4'd4, v0); check("R10 only flagged channel set", v0, 32'h40);
    check("R11 irq follows flag", {31'd0, irq}, 1);
    wr(4'd4, 32'h40);
    rd(4'd4, v0); check("R11 write-one clear", v0, 0);

    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule